// File: doc/BRIEF.md
# Rectangle Copy Blitter Engine

This block copies a rectangle of 8-bit pixels from a linear source memory into one of three 512x256 framebuffer planes. A host fills eight 16-bit registers through a simple write port and then starts a copy by raising a trigger bit. Every coordinate register carries two 8-bit fields: a source coordinate in the upper byte and a destination coordinate in the lower byte. Source and destination each have their own step-direction flags and half-plane select bits. The engine therefore supports mirrored copies, copies into either half of the plane, and copies from far into the source space.

The engine visits one destination pixel per clock. It reads the source byte through a combinational read port and issues a framebuffer write for each pixel that is visible. Pixel value zero is transparent. The exception is when the source rectangle measures exactly one step on both axes: the engine then treats the copy as a solid fill and replicates the single source pixel, zero included. Destination writes outside the visible window are dropped. When the copy ends the engine pulses an interrupt. Toggling the display-page bit in the flags register emits a one-cycle swap request. That request names the foreground buffer that must be shown and then cleared by the surrounding logic.

Top module: `blt_engine`

## Requirements
- R1: After reset, busy, irq, fb_we and page_swap are all 0.
- R2: A copy starts only when a write to register 6 changes its bit 14 from 0 to 1. A write to register 6 that finds bit 14 already at 1 starts nothing.
- R3: The engine visits (|XE[7:0]-XS[7:0]|+1) columns by (|YE[7:0]-YS[7:0]|+1) rows, one per cycle. The column index is the outer loop. The destination X and Y step up when flags bit 0 (X) or bit 1 (Y) is 1, and step down when it is 0.
- R4: The source coordinates start from the upper bytes of XS and YS and move in lock-step with the destination indices. They step up when flags bit 8 (X) or bit 9 (Y) is 1. Flags bit 10 adds 256 to the source X. The source byte address is (Y*512 + X) truncated to 24 bits, so negative values wrap.
- R5: Writes go to plane 0 (background) when register 6 bit 15 is 1. Otherwise they go to plane 1 (foreground A), or to plane 2 (foreground B) when flags bit 3 is 1.
- R6: A fetched pixel of value 0 is not written, except in fill mode.
- R7: Fill mode applies when |XE[15:8]-XS[15:8]| = 1 and |YE[15:8]-YS[15:8]| = 1. The source pixel at the start coordinates is then written to every visible destination pixel, zero included.
- R8: The destination X is taken modulo 256, and flags bit 2 adds 256 to it. A write is dropped when the screen X is 0, or when the destination Y is not in 1..255. The destination Y is not wrapped.
- R9: Busy is 1 from the cycle after the trigger write until the last pixel cycle. No write happens while busy is 0. Host writes while busy have no effect.
- R10: irq is a one-cycle pulse in the first cycle after busy falls.
- R11: A write to register 4 that changes bit 5 pulses page_swap for one cycle. page_src is 0 (foreground A) when the new bit is 1 and 1 (foreground B) when it is 0. A write that leaves bit 5 unchanged gives no pulse.
- R12: Flags bits 15:11 become source Y bits 12:8, and register 6 bit 8 adds 8192 to the source Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register word index |
| wr_data | input | 16 | Register write data |
| src_rd | output | 1 | Source read active |
| src_addr | output | 24 | Source byte address |
| src_data | input | 8 | Source byte, valid in the same cycle as src_addr |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_plane | output | 2 | Target plane: 0 background, 1 foreground A, 2 foreground B |
| fb_x | output | 9 | Framebuffer X, 0..511 |
| fb_y | output | 8 | Framebuffer Y |
| fb_data | output | 8 | Pixel written |
| busy | output | 1 | Copy in progress |
| irq | output | 1 | Completion pulse |
| page_swap | output | 1 | Display page swap request |
| page_src | output | 1 | Foreground buffer to show and clear |

## Verification
The hardest case to reach is the one where wrap, clipping and address truncation all meet. That happens when a destination column crosses X=255 into X=0 under the half select, when the destination Y walks below 1 or above 255, and when a decrementing source Y goes negative so that the 24-bit address wraps. The table vectors are chosen so that each of these crossings happens within a few pixels. A second hard case is a host write that arrives during a copy. The bench issues such writes mid-copy. It then shows through a later copy, and through a trigger that does not fire, that both the coordinate register and the trigger bit kept their old values.

// File: rtl/blt_pkg.sv
package blt_pkg;

    localparam int CW      = 8;              // coordinate field width
    localparam int DW      = 16;             // register width
    localparam int PIXW    = 8;              // pixel width
    localparam int AW      = 24;             // source address width
    localparam int NREG    = 8;
    localparam int RAW     = $clog2(NREG);
    localparam int YHI_W   = 5;              // flag bits feeding source Y
    localparam int PXW     = CW + 1;         // plane X width (512)
    localparam int SY0W    = CW + YHI_W + 1; // unsigned source Y base
    localparam int SXW     = PXW + 3;        // signed source X
    localparam int SYSW    = SY0W + 2;       // signed source Y
    localparam int FULLW   = SYSW + PXW + 1; // signed full address
    localparam int DYW     = CW + 2;         // signed destination Y

    localparam logic [RAW-1:0] REG_XS  = RAW'(0);
    localparam logic [RAW-1:0] REG_XE  = RAW'(1);
    localparam logic [RAW-1:0] REG_YS  = RAW'(2);
    localparam logic [RAW-1:0] REG_YE  = RAW'(3);
    localparam logic [RAW-1:0] REG_FLG = RAW'(4);
    localparam logic [RAW-1:0] REG_CTL = RAW'(6);

    localparam int F_DXUP  = 0;
    localparam int F_DYUP  = 1;
    localparam int F_DHALF = 2;
    localparam int F_FGB   = 3;
    localparam int F_PAGE  = 5;
    localparam int F_SXUP  = 8;
    localparam int F_SYUP  = 9;
    localparam int F_SHALF = 10;
    localparam int F_YHI_L = 11;
    localparam int C_Y13   = 8;
    localparam int C_GO    = 14;
    localparam int C_BG    = 15;

    localparam logic [SY0W-1:0] Y13_ADD = SY0W'(1 << 13);

    typedef enum logic [1:0] {
        PL_BG  = 2'd0,
        PL_FGA = 2'd1,
        PL_FGB = 2'd2
    } plane_e;

    typedef struct packed {
        logic [PXW-1:0]  sx0;
        logic [SY0W-1:0] sy0;
        logic            sx_up;
        logic            sy_up;
        logic [CW-1:0]   dx0;
        logic [CW-1:0]   dy0;
        logic            dx_up;
        logic            dy_up;
        logic            dhalf;
        logic [CW-1:0]   nx;     // column count minus one
        logic [CW-1:0]   ny;     // row count minus one
        logic            fill;
        plane_e          plane;
    } job_t;

    function automatic logic [CW-1:0] absd(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic job_t make_job(
        input logic [DW-1:0] xs, input logic [DW-1:0] xe,
        input logic [DW-1:0] ys, input logic [DW-1:0] ye,
        input logic [DW-1:0] flg, input logic [DW-1:0] ctl);
        job_t j;
        j.sx0   = {flg[F_SHALF], xs[DW-1:CW]};
        j.sy0   = {1'b0, flg[DW-1:F_YHI_L], ys[DW-1:CW]} + (ctl[C_Y13] ? Y13_ADD : '0);
        j.sx_up = flg[F_SXUP];
        j.sy_up = flg[F_SYUP];
        j.dx0   = xs[CW-1:0];
        j.dy0   = ys[CW-1:0];
        j.dx_up = flg[F_DXUP];
        j.dy_up = flg[F_DYUP];
        j.dhalf = flg[F_DHALF];
        j.nx    = absd(xe[CW-1:0], xs[CW-1:0]);
        j.ny    = absd(ye[CW-1:0], ys[CW-1:0]);
        j.fill  = (absd(xe[DW-1:CW], xs[DW-1:CW]) == CW'(1)) &&
                  (absd(ye[DW-1:CW], ys[DW-1:CW]) == CW'(1));
        j.plane = ctl[C_BG] ? PL_BG : (flg[F_FGB] ? PL_FGB : PL_FGA);
        return j;
    endfunction

endpackage

// File: rtl/blt_regs.sv
module blt_regs
    import blt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           busy,
    output logic           start,
    output job_t           job,
    output logic           page_swap,
    output logic           page_src
);

    logic [DW-1:0] regs [NREG];
    logic          wr_ok;
    logic          flip;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (wr_addr == REG_CTL) && wr_data[C_GO] && !regs[REG_CTL][C_GO];
    assign flip  = wr_ok && (wr_addr == REG_FLG) && (wr_data[F_PAGE] != regs[REG_FLG][F_PAGE]);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_ok && wr_addr == RAW'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            job       <= '0;
            page_swap <= 1'b0;
            page_src  <= 1'b0;
        end else begin
            if (start)
                job <= make_job(regs[REG_XS], regs[REG_XE], regs[REG_YS],
                                regs[REG_YE], regs[REG_FLG], wr_data);
            page_swap <= flip;
            if (flip)
                page_src <= !wr_data[F_PAGE];
        end
    end

    logic unused_regs;
    assign unused_regs = ^{regs[5], regs[7]};

endmodule

// File: rtl/blt_seq.sv
module blt_seq
    import blt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] nx,
    input  logic [CW-1:0] ny,
    output logic          busy,
    output logic [CW-1:0] ix,
    output logic [CW-1:0] iy,
    output logic          irq
);

    typedef enum logic {S_IDLE, S_RUN} seq_e;
    seq_e state;

    assign busy = (state == S_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ix    <= '0;
            iy    <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_RUN;
                        ix    <= '0;
                        iy    <= '0;
                    end
                end
                S_RUN: begin
                    if (iy == ny) begin
                        iy <= '0;
                        if (ix == nx) begin
                            state <= S_IDLE;
                            irq   <= 1'b1;
                        end else begin
                            ix <= ix + 1'b1;
                        end
                    end else begin
                        iy <= iy + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blt_addr.sv
module blt_addr
    import blt_pkg::*;
(
    input  job_t           job,
    input  logic [CW-1:0]  ix,
    input  logic [CW-1:0]  iy,
    output logic [AW-1:0]  src_addr,
    output logic [PXW-1:0] dst_x,
    output logic [CW-1:0]  dst_y,
    output logic           visible
);

    logic        [CW-1:0]    sxi, syi;
    logic signed [SXW-1:0]   xx;
    logic signed [SYSW-1:0]  yy;
    logic signed [FULLW-1:0] full;
    logic        [CW-1:0]    x8;
    logic signed [DYW-1:0]   yd;

    always_comb begin
        sxi = job.fill ? '0 : ix;
        syi = job.fill ? '0 : iy;
        xx  = job.sx_up ? $signed({3'b0, job.sx0}) + $signed({4'b0, sxi})
                        : $signed({3'b0, job.sx0}) - $signed({4'b0, sxi});
        yy  = job.sy_up ? $signed({2'b0, job.sy0}) + $signed({(SYSW-CW)'(0), syi})
                        : $signed({2'b0, job.sy0}) - $signed({(SYSW-CW)'(0), syi});
        full = $signed({{(FULLW-SYSW-PXW){yy[SYSW-1]}}, yy, {PXW{1'b0}}})
             + $signed({{(FULLW-SXW){xx[SXW-1]}}, xx});
        src_addr = full[AW-1:0];

        x8    = job.dx_up ? job.dx0 + ix : job.dx0 - ix;
        dst_x = {job.dhalf, x8};
        yd    = job.dy_up ? $signed({2'b0, job.dy0}) + $signed({2'b0, iy})
                          : $signed({2'b0, job.dy0}) - $signed({2'b0, iy});
        dst_y = yd[CW-1:0];
        visible = (dst_x != '0) && !yd[DYW-1] && !yd[CW] && (yd[CW-1:0] != '0);
    end

endmodule

// File: rtl/blt_engine.sv
module blt_engine
    import blt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic            src_rd,
    output logic [AW-1:0]   src_addr,
    input  logic [PIXW-1:0] src_data,
    output logic            fb_we,
    output logic [1:0]      fb_plane,
    output logic [PXW-1:0]  fb_x,
    output logic [CW-1:0]   fb_y,
    output logic [PIXW-1:0] fb_data,
    output logic            busy,
    output logic            irq,
    output logic            page_swap,
    output logic            page_src
);

    job_t          job;
    logic          start;
    logic [CW-1:0] ix, iy;
    logic          visible;

    blt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .start(start), .job(job),
        .page_swap(page_swap), .page_src(page_src)
    );

    blt_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .nx(job.nx), .ny(job.ny),
        .busy(busy), .ix(ix), .iy(iy), .irq(irq)
    );

    blt_addr u_addr (
        .job(job), .ix(ix), .iy(iy), .src_addr(src_addr),
        .dst_x(fb_x), .dst_y(fb_y), .visible(visible)
    );

    assign src_rd   = busy;
    assign fb_plane = job.plane;
    assign fb_data  = src_data;
    assign fb_we    = busy && visible && (job.fill || src_data != '0);

endmodule

// File: rtl/blt_engine_chk.sv
module blt_engine_chk
    import blt_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [RAW-1:0] wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic           busy,
    input logic           irq,
    input logic           fb_we,
    input logic [1:0]     fb_plane,
    input logic [PXW-1:0] fb_x,
    input logic [CW-1:0]  fb_y,
    input logic           page_swap
);

    assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fb_we);

    assert_irq_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(busy)));

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && wr_addr == REG_CTL && wr_data[C_GO]));

    assert_plane_legal_R5: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_plane != 2'd3));

    assert_clip_edge_R8: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_x != '0 && fb_y != '0));

    assert_swap_cause_R11: assert property (@(posedge clk) disable iff (rst)
        page_swap |-> $past(wr_en && wr_addr == REG_FLG && !busy));

endmodule

bind blt_engine blt_engine_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .irq(irq), .fb_we(fb_we), .fb_plane(fb_plane),
    .fb_x(fb_x), .fb_y(fb_y), .page_swap(page_swap)
);

// File: tb/sim_blt_engine.sv
`timescale 1ns/1ps
module sim_blt_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        src_rd;
    logic [23:0] src_addr;
    logic [7:0]  src_data;
    logic        fb_we;
    logic [1:0]  fb_plane;
    logic [8:0]  fb_x;
    logic [7:0]  fb_y;
    logic [7:0]  fb_data;
    logic        busy, irq, page_swap, page_src;

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [7:0] mem(input logic [23:0] a);
        return (a[1:0] == 2'b00) ? 8'h00 : (a[7:0] ^ a[15:8] ^ a[23:16]);
    endfunction
    assign src_data = mem(src_addr);

    blt_engine u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
        .fb_we(fb_we), .fb_plane(fb_plane), .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data),
        .busy(busy), .irq(irq), .page_swap(page_swap), .page_src(page_src)
    );

    // {xs, xe, ys, ye, flags, ctrl (no trigger), expected busy cycles}
    localparam int NV = 6;
    localparam logic [111:0] VEC [NV] = '{
        {16'h0A14, 16'h0D17, 16'h0530, 16'h0832, 16'h0303, 16'h0000, 16'd12},  // all up
        {16'h2010, 16'h1D0E, 16'h4005, 16'h3E02, 16'h0000, 16'h0000, 16'd12},  // all down
        {16'h3001, 16'h3203, 16'h0002, 16'h0200, 16'h0000, 16'h8000, 16'd9},   // clip, bg, neg src
        {16'h50FE, 16'h5301, 16'h60FE, 16'h61FF, 16'h9F0F, 16'h0100, 16'd508}, // halves, fg B, high Y
        {16'h4008, 16'h410C, 16'h0010, 16'h0112, 16'h0303, 16'h0000, 16'd15},  // fill with zero
        {16'h0705, 16'h0805, 16'h02FE, 16'h03FB, 16'h0303, 16'h0000, 16'd4}    // Y past 255
    };

    int nchk = 0;
    int nerr = 0;

    logic [26:0] act_w [1024];
    logic [26:0] exp_w [1024];
    int          wn, en, bcnt, icnt;
    logic [23:0] a0, ea0;
    logic        cap_en = 1'b0;
    logic        cap_prev = 1'b0;

    always @(negedge clk) begin
        if (cap_en && !cap_prev) begin
            wn = 0; bcnt = 0; icnt = 0;
        end
        if (cap_en) begin
            if (busy) begin
                if (bcnt == 0) a0 = src_addr;
                bcnt++;
            end
            if (fb_we && wn < 1024) begin
                act_w[wn] = {fb_plane, fb_x, fb_y, fb_data};
                wn++;
            end
            if (irq) icnt++;
        end
        cap_prev = cap_en;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic model(input logic [111:0] v);
        logic [15:0] xs, xe, ys, ye, fl, ct;
        int sx0, sy0, nx, ny, xx, yy, a, xd, sxd, yd, pl;
        bit fill;
        logic [7:0] pix;
        {xs, xe, ys, ye, fl, ct} = v[111:16];
        sx0  = int'(xs[15:8]) + (fl[10] ? 256 : 0);
        sy0  = int'(ys[15:8]) + int'(fl[15:11]) * 256 + (ct[8] ? 8192 : 0);
        fill = ((int'(xe[15:8]) - int'(xs[15:8]) == 1) || (int'(xs[15:8]) - int'(xe[15:8]) == 1)) &&
               ((int'(ye[15:8]) - int'(ys[15:8]) == 1) || (int'(ys[15:8]) - int'(ye[15:8]) == 1));
        nx = int'(xe[7:0]) - int'(xs[7:0]); if (nx < 0) nx = -nx;
        ny = int'(ye[7:0]) - int'(ys[7:0]); if (ny < 0) ny = -ny;
        pl = ct[15] ? 0 : (fl[3] ? 2 : 1);
        en = 0;
        for (int ix = 0; ix <= nx; ix++) begin
            for (int iy = 0; iy <= ny; iy++) begin
                xx = fill ? sx0 : (fl[8] ? sx0 + ix : sx0 - ix);
                yy = fill ? sy0 : (fl[9] ? sy0 + iy : sy0 - iy);
                a  = (yy * 512 + xx) & 32'h00FF_FFFF;
                pix = mem(a[23:0]);
                xd  = (int'(xs[7:0]) + (fl[0] ? ix : -ix)) & 255;
                sxd = xd + (fl[2] ? 256 : 0);
                yd  = int'(ys[7:0]) + (fl[1] ? iy : -iy);
                if (ix == 0 && iy == 0) ea0 = a[23:0];
                if ((pix != 0 || fill) && sxd > 0 && yd > 0 && yd < 256) begin
                    exp_w[en] = {pl[1:0], sxd[8:0], yd[7:0], pix};
                    en++;
                end
            end
        end
    endtask

    task automatic arm_and_fire(input logic [111:0] v);
        cap_en = 1'b1;
        hw(3'd6, v[31:16] | 16'h4000);
    endtask

    task automatic finish_and_check(input logic [111:0] v, input string tag);
        int bad;
        logic [26:0] ba, be;
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        cap_en = 1'b0;
        model(v);
        check(bcnt == int'(v[15:0]), {tag, " R3 busy cycles"}, bcnt, v[15:0]);
        check(icnt == 1, {tag, " R10 irq pulses"}, icnt, 1);
        check(a0 == ea0, {tag, " R4 R12 first source address"}, a0, ea0);
        check(wn == en, {tag, " R6 R8 write count"}, wn, en);
        bad = 0; ba = '0; be = '0;
        for (int k = 0; k < en && k < wn; k++)
            if (act_w[k] !== exp_w[k] && bad == 0) begin
                bad = 1; ba = act_w[k]; be = exp_w[k];
            end
        check(bad == 0, {tag, " R3 R4 R5 R7 write contents"}, ba, be);
    endtask

    task automatic run_vec(input logic [111:0] v, input string tag);
        hw(3'd0, v[111:96]);
        hw(3'd1, v[95:80]);
        hw(3'd2, v[79:64]);
        hw(3'd3, v[63:48]);
        hw(3'd4, v[47:32]);
        hw(3'd6, v[31:16]);
        arm_and_fire(v);
        finish_and_check(v, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(fb_we == 0, "R1 fb_we after reset", fb_we, 0);
        check(page_swap == 0, "R1 page_swap after reset", page_swap, 0);

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i], $sformatf("vec%0d", i));

        // R9: writes during a copy have no effect
        hw(3'd0, VEC[0][111:96]);
        hw(3'd1, VEC[0][95:80]);
        hw(3'd2, VEC[0][79:64]);
        hw(3'd3, VEC[0][63:48]);
        hw(3'd4, VEC[0][47:32]);
        hw(3'd6, 16'h0000);
        arm_and_fire(VEC[0]);
        check(busy == 1, "R9 busy after trigger", busy, 1);
        hw(3'd0, 16'hFFFF);
        hw(3'd6, 16'h0000);
        finish_and_check(VEC[0], "busywr");
        // R2: trigger bit still 1 (clear was ignored), so rewriting 1 starts nothing
        hw(3'd6, 16'h4000);
        check(busy == 0, "R2 R9 no start on 1-to-1", busy, 0);
        @(negedge clk);
        check(busy == 0, "R2 still idle", busy, 0);
        // new copy proves register 0 kept its value (R9)
        hw(3'd6, 16'h0000);
        arm_and_fire(VEC[0]);
        finish_and_check(VEC[0], "R9 reg0 kept");

        // R11 page swap
        hw(3'd4, 16'h0020);
        check(page_swap == 1 && page_src == 0, "R11 swap to A",
              {page_swap, page_src}, 2'b10);
        @(negedge clk);
        check(page_swap == 0, "R11 swap is a pulse", page_swap, 0);
        hw(3'd4, 16'h0020);
        check(page_swap == 0, "R11 no swap when unchanged", page_swap, 0);
        hw(3'd4, 16'h0000);
        check(page_swap == 1 && page_src == 1, "R11 swap to B",
              {page_swap, page_src}, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule